// File: doc/BRIEF.md
# Multi-Mode Self-Test Register

A bank of flip-flops whose behaviour is chosen each clock by a 2-bit mode input. It can act as a plain parallel register, clear itself, or link its stages into a serial shift chain so its contents can be read out and new contents written in. In self-test it acts as a linear feedback shift register. With the parallel inputs held at zero it steps through a maximal-length pseudo-random sequence that can drive a logic block under test. With those inputs carrying the block's responses, it compacts them into a signature.

The register sits between logic blocks on a chip. A test controller, outside this block, first seeds a nonzero value through the shift chain. It then runs self-test for a fixed number of cycles and finally shifts the signature out for comparison. The stage count is a parameter with a default of 3. The feedback tap mask is derived from the width and can be overridden.

Top module: `multimode_test_reg`

## Requirements
- R1: An active-low asynchronous reset clears every stage to 0 at once, without waiting for a clock edge.
- R2: Mode 2'b11 (load) makes each stage i capture `par_d_i[i]` on the rising clock edge.
- R3: Mode 2'b10 (clear) sets every stage to 0 on the rising clock edge, regardless of data and serial inputs.
- R4: Mode 2'b00 (shift) moves stage i into stage i+1 and `scan_in_i` into stage 0 on each rising edge. `par_d_i` has no effect in this mode.
- R5: Mode 2'b01 (self-test) with `par_d_i` at zero moves stage i into stage i+1 and loads stage 0 with the XOR of the tapped stages, which are bits 2 and 0 at width 3. Written as `par_q_o[2:0]` from 3'b111, the states are 110, 101, 010, 100, 001, 011, and then 111 again, a period of 7.
- R6: In self-test, each `par_d_i[i]` is XORed into the next value of stage i. From 3'b111, the data sequence 001, 010, 100 leaves the signature 3'b101.
- R7: In self-test, the all-zero state with zero data stays all-zero.
- R8: `scan_out_o` always equals the last stage `par_q_o[WIDTH-1]`. In shift mode, a loaded word therefore leaves the chip most significant bit first, one bit per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 00 shift, 01 self-test, 10 clear, 11 load |
| par_d_i | input | WIDTH | Parallel data, or responses to compact in self-test |
| scan_in_i | input | 1 | Serial input to stage 0 in shift mode |
| par_q_o | output | WIDTH | Register contents |
| scan_out_o | output | 1 | Serial output, the last stage |

## Verification
Every stage is visible on `par_q_o`, so a wrong next-state value in any mode shows at the ports on the very next rising edge. A wrong feedback tap may leave the first few self-test steps correct only by chance, but it breaks the seven-state cycle within one period. A lost XOR of a data bit changes the signature in the same cycle that the bit is applied. The bench runs a behavioural model beside the design and compares its state after every edge. This catches a divergence in the cycle where it first appears, rather than only in the final signature.

// File: rtl/mmtr_pkg.sv
package mmtr_pkg;

  typedef enum logic [1:0] {
    MODE_SHIFT    = 2'b00,
    MODE_SELFTEST = 2'b01,
    MODE_CLEAR    = 2'b10,
    MODE_LOAD     = 2'b11
  } mode_e;

  // maximal-length tap masks, feedback into stage 0, shift toward MSB
  function automatic logic [63:0] default_taps(input int unsigned width);
    case (width)
      2:       return 64'h3;
      3:       return 64'h5;
      4:       return 64'hC;
      5:       return 64'h14;
      6:       return 64'h30;
      7:       return 64'h60;
      8:       return 64'hB8;
      9:       return 64'h110;
      10:      return 64'h240;
      11:      return 64'h500;
      15:      return 64'h6000;
      16:      return 64'hB400;
      default: return (64'h1 << (width - 1)) | 64'h1;
    endcase
  endfunction

endpackage

// File: rtl/mmtr_feedback.sv
module mmtr_feedback #(
  parameter int unsigned     WIDTH    = 3,
  parameter logic [WIDTH-1:0] TAP_MASK = '1
) (
  input  logic [WIDTH-1:0] state_i,
  output logic             fb_o
);

  logic [WIDTH-1:0] tapped;

  assign tapped = state_i & TAP_MASK;
  assign fb_o   = ^tapped;

endmodule

// File: rtl/mmtr_stage_mux.sv
module mmtr_stage_mux
  import mmtr_pkg::*;
#(
  parameter int unsigned WIDTH = 3
) (
  input  mode_e            mode_i,
  input  logic [WIDTH-2:0] low_q_i,
  input  logic             head_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] nxt_o
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    logic shifted;
    if (i == 0) begin : g_head
      assign shifted = head_i;
    end else begin : g_link
      assign shifted = low_q_i[i-1];
    end

    always_comb begin
      unique case (mode_i)
        MODE_SHIFT:    nxt_o[i] = shifted;
        MODE_SELFTEST: nxt_o[i] = shifted ^ d_i[i];
        MODE_CLEAR:    nxt_o[i] = 1'b0;
        default:       nxt_o[i] = d_i[i];
      endcase
    end
  end

endmodule

// File: rtl/multimode_test_reg.sv
module multimode_test_reg
  import mmtr_pkg::*;
#(
  parameter int unsigned      WIDTH    = 3,
  parameter logic [WIDTH-1:0] TAP_MASK = WIDTH'(default_taps(WIDTH))
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic [WIDTH-1:0] par_d_i,
  input  logic             scan_in_i,
  output logic [WIDTH-1:0] par_q_o,
  output logic             scan_out_o
);

  localparam int unsigned LAST = WIDTH - 1;

  mode_e            mode;
  logic             fb;
  logic             head;
  logic [WIDTH-1:0] q_q;
  logic [WIDTH-1:0] q_d;

  assign mode = mode_e'(mode_i);

  mmtr_feedback #(
    .WIDTH   (WIDTH),
    .TAP_MASK(TAP_MASK)
  ) u_fb (
    .state_i(q_q),
    .fb_o   (fb)
  );

  // first-stage source: serial input while shifting, feedback otherwise
  assign head = (mode == MODE_SHIFT) ? scan_in_i : fb;

  mmtr_stage_mux #(
    .WIDTH(WIDTH)
  ) u_mux (
    .mode_i (mode),
    .low_q_i(q_q[WIDTH-2:0]),
    .head_i (head),
    .d_i    (par_d_i),
    .nxt_o  (q_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_d;
  end

  assign par_q_o    = q_q;
  assign scan_out_o = q_q[LAST];

endmodule

// File: rtl/mmtr_checker.sv
module mmtr_checker #(
  parameter int unsigned      WIDTH    = 3,
  parameter logic [WIDTH-1:0] TAP_MASK = '1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       mode_i,
  input logic [WIDTH-1:0] par_d_i,
  input logic             scan_in_i,
  input logic [WIDTH-1:0] par_q_o,
  input logic             scan_out_o
);

  a_r2_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b11 |=> par_q_o == $past(par_d_i));

  a_r3_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b10 |=> par_q_o == '0);

  a_r4_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b00 |=> par_q_o == {$past(par_q_o[WIDTH-2:0]), $past(scan_in_i)});

  a_r6_compact: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b01 |=>
      par_q_o == ({$past(par_q_o[WIDTH-2:0]), ^($past(par_q_o) & TAP_MASK)} ^ $past(par_d_i)));

  a_r7_lockup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b01 && par_q_o == '0 && par_d_i == '0) |=> par_q_o == '0);

  a_r8_serial_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b00 |=> scan_out_o == $past(par_q_o[WIDTH-2]));

endmodule

bind multimode_test_reg mmtr_checker #(
  .WIDTH   (WIDTH),
  .TAP_MASK(TAP_MASK)
) u_chk (.*);

// File: tb/multimode_test_reg_tb_top.sv
module multimode_test_reg_tb_top;

  localparam int W = 3;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [1:0]   mode_i = 2'b11;
  logic [W-1:0] par_d_i = '0;
  logic         scan_in_i = 1'b0;
  logic [W-1:0] par_q_o;
  logic         scan_out_o;

  int n_chk = 0;
  int n_fail = 0;
  int model = 0;
  bit done = 1'b0;

  multimode_test_reg #(.WIDTH(W)) dut_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode_i),
    .par_d_i   (par_d_i),
    .scan_in_i (scan_in_i),
    .par_q_o   (par_q_o),
    .scan_out_o(scan_out_o)
  );

  always #10 clk_i = ~clk_i;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  function automatic int ref_next(int m, int md, int d, int si);
    int fb;
    case (md)
      0: return ((m * 2) + si) % 8;
      1: begin
        fb = ((m / 4) + m) % 2;
        return (((m * 2) + fb) % 8) ^ d;
      end
      2: return 0;
      default: return d;
    endcase
  endfunction

  task automatic step(input int md, input int d, input int si, input string tag);
    int exp;
    mode_i    = md[1:0];
    par_d_i   = d[W-1:0];
    scan_in_i = si[0];
    exp = ref_next(model, md, d, si);
    @(posedge clk_i);
    @(negedge clk_i);
    model = exp;
    check(tag, int'(par_q_o), exp);
    check({tag, " scan_out"}, int'(scan_out_o), (exp / 4) % 2);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int seq [7] = '{6, 5, 2, 4, 1, 3, 7};
    repeat (3) @(negedge clk_i);
    check("R1 reset state", int'(par_q_o), 0);
    rst_ni = 1'b1;

    step(3, 5, 0, "R2 load 101");
    step(3, 2, 1, "R2 load 010");
    // R1: asynchronous clear between edges
    #3 rst_ni = 1'b0;
    #1 check("R1 async clear", int'(par_q_o), 0);
    model = 0;
    @(negedge clk_i);
    rst_ni = 1'b1;

    step(3, 7, 0, "R2 load 111");
    step(2, 5, 1, "R3 clear ignores inputs");

    // R8: loaded word leaves MSB first
    step(3, 6, 0, "R2 load 110");
    check("R8 first serial bit", int'(scan_out_o), 1);
    step(0, 7, 0, "R4 shift 1");
    check("R8 second serial bit", int'(scan_out_o), 1);
    step(0, 0, 1, "R4 shift 2");
    check("R8 third serial bit", int'(scan_out_o), 0);
    step(0, 5, 1, "R4 shift 3 data ignored");
    check("R4 seed 011", int'(par_q_o), 3);

    // seed 111, then free-running sequence
    for (int i = 0; i < 3; i++) step(0, 0, 1, "R4 seed shift");
    check("R4 seed 111", int'(par_q_o), 7);
    for (int i = 0; i < 7; i++) begin
      step(1, 0, 0, "R5 sequence");
      check("R5 sequence value", int'(par_q_o), seq[i]);
    end

    // R7: lock-up
    step(2, 0, 0, "R3 clear");
    for (int i = 0; i < 3; i++) step(1, 0, 0, "R7 zero stays zero");

    // R6: signature
    for (int i = 0; i < 3; i++) step(0, 0, 1, "R4 seed shift");
    step(1, 1, 0, "R6 compact 001");
    step(1, 2, 0, "R6 compact 010");
    step(1, 4, 0, "R6 compact 100");
    check("R6 signature 101", int'(par_q_o), 5);

    // mixed traffic against the model
    for (int i = 0; i < 60; i++)
      step(int'($urandom_range(3)), int'($urandom_range(7)), int'($urandom_range(1)),
           "R2 R3 R4 R6 mixed");

    finish_run();
  end

endmodule